// File: doc/BRIEF.md
# Processor Clock Power-State Controller

This block is the state machine that moves a processor core between its clock power states. It uses five named states. `PS_RUN` executes code normally. `PS_HALT` is the halted, auto-power-down state. `PS_GRANT` is entered after a stop request has been granted. `PS_SNOOP` is a short-lived state that serves an inquire cycle. `PS_STOPPED` is the state in which the external clock is absent. From the state it drives these controls:

- execution enable
- internal clock enable
- PLL enable
- hold acknowledge and bus float

It also reports the state as a 3-bit code.

The named transitions are as follows:

- **T_STOP** (`PS_RUN`/`PS_HALT` to `PS_GRANT`) is taken on a stop request when no interrupt is being serviced.
- **T_HALT** (`PS_RUN` to `PS_HALT`) is taken on a halt indication.
- **T_WAKE** (`PS_HALT` to `PS_RUN`) is taken on an interrupt.
- **T_RELEASE** (`PS_GRANT` to `PS_RUN`) is taken when the stop request is withdrawn.
- **T_INQ** (`PS_HALT`/`PS_GRANT` to `PS_SNOOP`) is taken on an inquire detect. It records the state the machine came from.
- **T_DONE** (`PS_SNOOP` back to the recorded state) is taken on the snoop-done strobe.
- **T_CLKOFF** (`PS_GRANT` to `PS_STOPPED`) is taken when the clock-present flag drops.
- **T_RESTART** (`PS_STOPPED` to `PS_GRANT`) is taken after a parameterised number of consecutive cycles with the clock present.

Hold handling works the same way in every state, including the clock-stopped one.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset the state code is 0 (`PS_RUN`), `exec_en`, `iclk_en` and `pll_en` are 1, and `hold_ack` and `bus_float` are 0.
- R2: In `PS_RUN`, `stop_req` high with `irq_busy` low moves the machine to `PS_GRANT` at the next clock edge. A stop request wins over a simultaneous `halt_req`.
- R3: While `irq_busy` is high, `stop_req` is not acted on. The move to `PS_GRANT` happens at the first edge that sees `irq_busy` low.
- R4: In `PS_RUN`, `halt_req` moves the machine to `PS_HALT`. In `PS_HALT`, `wake_irq` moves it back to `PS_RUN`. Without `wake_irq` or another event it stays in `PS_HALT`.
- R5: `PS_GRANT` ignores `wake_irq` and `irq_busy`. It returns to `PS_RUN` when `stop_req` is low and the clock is present.
- R6: `snoop_hit` in `PS_HALT` or `PS_GRANT` moves the machine to `PS_SNOOP`. `snoop_hit` in `PS_RUN` has no effect.
- R7: `PS_SNOOP` holds until `snoop_done` is seen. It then returns to exactly the state it was entered from (`PS_HALT` or `PS_GRANT`).
- R8: In `PS_GRANT`, `ext_clk_ok` low moves the machine to `PS_STOPPED`. This takes priority over `snoop_hit` and over a withdrawn `stop_req`.
- R9: `PS_STOPPED` moves to `PS_GRANT` on the RESTART_CYCLES-th consecutive clock edge with `ext_clk_ok` high (default 1000). A cycle with `ext_clk_ok` low restarts the count.
- R10: The state codes are `PS_RUN`=0, `PS_HALT`=1, `PS_GRANT`=2, `PS_SNOOP`=3 and `PS_STOPPED`=4. The enables {`exec_en`,`iclk_en`,`pll_en`} are 111 in `PS_RUN`, 001 in `PS_HALT`, 001 in `PS_GRANT`, 011 in `PS_SNOOP` and 000 in `PS_STOPPED`.
- R11: `hold_ack` and `bus_float` equal `hold_req` as sampled at the previous clock edge, in every state including `PS_STOPPED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Stop-clock request |
| halt_req | input | 1 | Halt indication from the core |
| irq_busy | input | 1 | An interrupt is being serviced |
| wake_irq | input | 1 | Interrupt that ends the halt |
| snoop_hit | input | 1 | Inquire cycle detected |
| snoop_done | input | 1 | Coherency operation finished |
| hold_req | input | 1 | Bus hold request |
| ext_clk_ok | input | 1 | External clock is present |
| exec_en | output | 1 | Instruction execution enabled |
| iclk_en | output | 1 | Internal clocks enabled |
| pll_en | output | 1 | PLL enabled |
| hold_ack | output | 1 | Hold acknowledge |
| bus_float | output | 1 | Bus drivers released |
| state_code | output | 3 | Current power state |

## Verification
Every state change is registered once, so the new state code and its enables appear one clock after the edge that samples the stimulus. `hold_ack` and `bus_float` also trail `hold_req` by exactly one edge. The restart from `PS_STOPPED` is due on the RESTART_CYCLES-th edge with the clock present. The bench checks the state one edge before that point and again on it, and it also checks that a clock drop restarts the count. Stimulus is driven on the falling edge and results are read on the following falling edge, after the given number of rising edges.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_HALT    = 3'd1,
        PS_GRANT   = 3'd2,
        PS_SNOOP   = 3'd3,
        PS_STOPPED = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic exec;
        logic iclk;
        logic pll;
    } pwr_en_t;

endpackage

// File: rtl/pcs_restart_timer.sv
module pcs_restart_timer #(
    parameter int RESTART_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic done
);
    localparam int CNT_W = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RESTART_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !count_en) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = count_en && (cnt_q == LAST);

    // count never passes the last value
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // dropping enable always restarts from zero
    assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> cnt_q == '0);
endmodule

// File: rtl/pcs_hold_ctrl.sv
module pcs_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    output logic hold_ack,
    output logic bus_float
);
    logic ack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= hold_req;
        end
    end

    assign hold_ack  = ack_q;
    assign bus_float = ack_q;

    assert_hold_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> hold_ack);

    assert_hold_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_req |=> !hold_ack && !bus_float);
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       halt_req,
    input  logic       irq_busy,
    input  logic       wake_irq,
    input  logic       snoop_hit,
    input  logic       snoop_done,
    input  logic       ext_clk_ok,
    input  logic       restart_done,
    output logic       timer_en,
    output pwr_en_t    en,
    output logic [2:0] state_code
);
    pwr_state_e state_q, state_d;
    pwr_state_e ret_q, ret_d;
    logic       stop_ok;

    assign stop_ok = stop_req && !irq_busy;

    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        unique case (state_q)
            PS_RUN: begin
                if (stop_ok) begin
                    state_d = PS_GRANT;
                end else if (halt_req) begin
                    state_d = PS_HALT;
                end
            end
            PS_HALT: begin
                if (snoop_hit) begin
                    state_d = PS_SNOOP;
                    ret_d   = PS_HALT;
                end else if (wake_irq) begin
                    state_d = PS_RUN;
                end else if (stop_ok) begin
                    state_d = PS_GRANT;
                end
            end
            PS_GRANT: begin
                if (!ext_clk_ok) begin
                    state_d = PS_STOPPED;
                end else if (snoop_hit) begin
                    state_d = PS_SNOOP;
                    ret_d   = PS_GRANT;
                end else if (!stop_req) begin
                    state_d = PS_RUN;
                end
            end
            PS_SNOOP: begin
                if (snoop_done) begin
                    state_d = ret_q;
                end
            end
            PS_STOPPED: begin
                if (restart_done) begin
                    state_d = PS_GRANT;
                end
            end
            default: begin
                state_d = PS_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            ret_q   <= PS_HALT;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    always_comb begin
        en = '{exec: 1'b0, iclk: 1'b0, pll: 1'b0};
        unique case (state_q)
            PS_RUN:     en = '{exec: 1'b1, iclk: 1'b1, pll: 1'b1};
            PS_HALT:    en = '{exec: 1'b0, iclk: 1'b0, pll: 1'b1};
            PS_GRANT:   en = '{exec: 1'b0, iclk: 1'b0, pll: 1'b1};
            PS_SNOOP:   en = '{exec: 1'b0, iclk: 1'b1, pll: 1'b1};
            PS_STOPPED: en = '{exec: 1'b0, iclk: 1'b0, pll: 1'b0};
            default:    en = '{exec: 1'b0, iclk: 1'b0, pll: 1'b0};
        endcase
    end

    assign timer_en   = (state_q == PS_STOPPED) && ext_clk_ok;
    assign state_code = state_q;

    assert_ret_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PS_SNOOP |-> (ret_q == PS_HALT || ret_q == PS_GRANT));

    assert_snoop_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SNOOP && snoop_done) |=> state_q == $past(ret_q));

    assert_snoop_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == PS_SNOOP) |->
            ($past(state_q) == PS_HALT || $past(state_q) == PS_GRANT));

    assert_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && irq_busy) |=> state_q != PS_GRANT);

    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_GRANT && stop_req && ext_clk_ok && !snoop_hit) |=> state_q == PS_GRANT);

    assert_stop_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STOPPED && $past(state_q) != PS_STOPPED) |-> $past(state_q) == PS_GRANT);

    assert_stop_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PS_STOPPED |-> !en.pll && !en.iclk && !en.exec);
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
    import pcs_pkg::*;
#(
    parameter int RESTART_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       halt_req,
    input  logic       irq_busy,
    input  logic       wake_irq,
    input  logic       snoop_hit,
    input  logic       snoop_done,
    input  logic       hold_req,
    input  logic       ext_clk_ok,
    output logic       exec_en,
    output logic       iclk_en,
    output logic       pll_en,
    output logic       hold_ack,
    output logic       bus_float,
    output logic [2:0] state_code
);
    logic    timer_en;
    logic    restart_done;
    pwr_en_t en;

    pcs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req     (stop_req),
        .halt_req     (halt_req),
        .irq_busy     (irq_busy),
        .wake_irq     (wake_irq),
        .snoop_hit    (snoop_hit),
        .snoop_done   (snoop_done),
        .ext_clk_ok   (ext_clk_ok),
        .restart_done (restart_done),
        .timer_en     (timer_en),
        .en           (en),
        .state_code   (state_code)
    );

    pcs_restart_timer #(
        .RESTART_CYCLES (RESTART_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (timer_en),
        .done     (restart_done)
    );

    pcs_hold_ctrl u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .hold_ack  (hold_ack),
        .bus_float (bus_float)
    );

    assign exec_en = en.exec;
    assign iclk_en = en.iclk;
    assign pll_en  = en.pll;
endmodule

// File: tb/clk_pwr_ctrl_tb.sv
module clk_pwr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 1000;

    logic clk = 1'b0;
    logic rst_n, stop_req, halt_req, irq_busy, wake_irq;
    logic snoop_hit, snoop_done, hold_req, ext_clk_ok;
    logic exec_en, iclk_en, pll_en, hold_ack, bus_float;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_pwr_ctrl #(.RESTART_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .halt_req(halt_req),
        .irq_busy(irq_busy), .wake_irq(wake_irq), .snoop_hit(snoop_hit),
        .snoop_done(snoop_done), .hold_req(hold_req), .ext_clk_ok(ext_clk_ok),
        .exec_en(exec_en), .iclk_en(iclk_en), .pll_en(pll_en),
        .hold_ack(hold_ack), .bus_float(bus_float), .state_code(state_code)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_en(input string req, input int exp);
        chk(req, {exec_en, iclk_en, pll_en}, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; stop_req = 0; halt_req = 0; irq_busy = 0; wake_irq = 0;
        snoop_hit = 0; snoop_done = 0; hold_req = 0; ext_clk_ok = 1;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 state", state_code, 0);
        chk_en("R1 enables", 3'b111);
        chk("R1 hold_ack", hold_ack, 0);
        chk("R1 bus_float", bus_float, 0);
    endtask

    task automatic t_stop_grant;
        stop_req = 1; halt_req = 1;
        step(1);
        chk("R2 stop beats halt", state_code, 2);
        chk_en("R10 grant enables", 3'b001);
        stop_req = 0; halt_req = 0;
        step(1);
        chk("R5 release to run", state_code, 0);
    endtask

    task automatic t_defer;
        irq_busy = 1; stop_req = 1;
        step(3);
        chk("R3 deferred", state_code, 0);
        irq_busy = 0;
        step(1);
        chk("R3 taken after irq", state_code, 2);
        wake_irq = 1; irq_busy = 1;
        step(2);
        chk("R5 irq ignored in grant", state_code, 2);
        wake_irq = 0; irq_busy = 0; stop_req = 0;
        step(1);
        chk("R5 back to run", state_code, 0);
    endtask

    task automatic t_halt;
        snoop_hit = 1;
        step(1);
        chk("R6 hit ignored in run", state_code, 0);
        snoop_hit = 0;
        halt_req = 1;
        step(1);
        chk("R4 halt entry", state_code, 1);
        chk_en("R10 halt enables", 3'b001);
        halt_req = 0;
        step(2);
        chk("R4 halt holds", state_code, 1);
        wake_irq = 1;
        step(1);
        chk("R4 wake to run", state_code, 0);
        wake_irq = 0;
    endtask

    task automatic t_snoop_halt;
        halt_req = 1;
        step(1);
        halt_req = 0; snoop_hit = 1;
        step(1);
        chk("R6 snoop from halt", state_code, 3);
        chk_en("R10 snoop enables", 3'b011);
        snoop_hit = 0;
        step(3);
        chk("R7 snoop waits", state_code, 3);
        snoop_done = 1;
        step(1);
        chk("R7 return to halt", state_code, 1);
        snoop_done = 0; wake_irq = 1;
        step(1);
        wake_irq = 0;
        chk("R4 wake after snoop", state_code, 0);
    endtask

    task automatic t_snoop_grant;
        stop_req = 1;
        step(1);
        snoop_hit = 1;
        step(1);
        chk("R6 snoop from grant", state_code, 3);
        snoop_hit = 0; stop_req = 0;
        step(1);
        chk("R7 holds without done", state_code, 3);
        snoop_done = 1;
        step(1);
        chk("R7 return to grant", state_code, 2);
        snoop_done = 0;
        step(1);
        chk("R5 release after snoop", state_code, 0);
    endtask

    task automatic t_stopclk;
        stop_req = 1;
        step(1);
        ext_clk_ok = 0; snoop_hit = 1;
        step(1);
        chk("R8 clock loss wins", state_code, 4);
        chk_en("R10 stopped enables", 3'b000);
        snoop_hit = 0;
        hold_req = 1;
        step(1);
        chk("R11 hold_ack in stopped", hold_ack, 1);
        chk("R11 bus_float in stopped", bus_float, 1);
        hold_req = 0;
        step(1);
        chk("R11 hold_ack drops", hold_ack, 0);
        chk("R11 bus driven again", bus_float, 0);
        ext_clk_ok = 1;
        step(N - 1);
        ext_clk_ok = 0;
        step(1);
        chk("R9 drop restarts", state_code, 4);
        ext_clk_ok = 1;
        step(N - 1);
        chk("R9 not yet", state_code, 4);
        step(1);
        chk("R9 restart to grant", state_code, 2);
        stop_req = 0;
        step(1);
        chk("R5 run after restart", state_code, 0);
    endtask

    task automatic t_hold_run;
        hold_req = 1;
        step(1);
        chk("R11 hold_ack in run", hold_ack, 1);
        hold_req = 0;
        step(1);
        chk("R11 hold_ack release", hold_ack, 0);
    endtask

    initial begin
        t_reset();
        t_stop_grant();
        t_defer();
        t_halt();
        t_snoop_halt();
        t_snoop_grant();
        t_stopclk();
        t_hold_run();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule